// File: doc/BRIEF.md
# Interrupt Status and Bus-Error Latch

This block gathers two interrupt sources of a disk channel, the channel's own completion interrupt and a bus error seen during a DMA transfer, into a small register window. Software enables sources through a set-only enable register, reads a status register and acknowledges through a write-one-to-clear register. A single level interrupt output stays high while any status bit is set.

When a bus error is recorded, the faulting bus address is captured and made readable as a low and a high 32-bit word. Only the first error is kept: later errors do not overwrite the captured address until software clears the error status bit. As an additional acknowledge path, a read of the attached device's status byte that shows the device no longer busy (any bit of a configurable mask set) clears both pending status bits with no register write. An event arriving in the same cycle as any clear always wins, so no interrupt is lost.

Top module: `irqerr_latch`

## Requirements
- R1: After reset the status bits, the enable bits and the captured address are all zero, `irq_o` is low and `reg_rdata` is zero.
- R2: A write to byte offset 0x14 sets each enable bit n whose `reg_wdata[n]` is 1 (bit 0 channel, bit 1 bus error) and leaves the others; a read of 0x14 returns the enable bits in bits 1:0.
- R3: A `chan_evt` pulse sets status bit 0 and a `berr_evt` pulse sets status bit 1, each only when its enable bit is already 1; an event on a disabled source leaves the status unchanged.
- R4: `irq_o` is high exactly while at least one status bit is set.
- R5: A write to byte offset 0x1C clears each status bit n whose `reg_wdata[n]` is 1 and leaves bits written with 0 unchanged.
- R6: An enabled event in the same cycle as a clear write or a clear-on-read leaves its status bit set.
- R7: The address on `berr_addr` at the first recorded bus error is readable at byte offset 0x00 (bits 31:0) and 0x04 (bits 63:32); further errors while status bit 1 is set do not change it.
- R8: Once status bit 1 has been cleared (or is being cleared in the same cycle), the next recorded bus error captures its new address.
- R9: A `dev_stat_rd` pulse with `dev_stat_byte & 0x51` nonzero clears both status bits; with the masked value zero (for example 0x80, busy) it has no effect.
- R10: A read of byte offset 0x0C returns the status bits in bits 1:0; `reg_rdata` is updated one cycle after `reg_rd`, and reads of unassigned or non-word-aligned offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Byte offset within the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| chan_evt | input | 1 | Channel interrupt event pulse |
| berr_evt | input | 1 | Bus error event pulse |
| berr_addr | input | 64 | Faulting bus address, valid with `berr_evt` |
| dev_stat_rd | input | 1 | Pulse: software read the device status byte |
| dev_stat_byte | input | 8 | Value of that device status byte |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The hardest situations to reach are the same-cycle collisions: an event coinciding with a register clear or a clear-on-read, and a second bus error arriving in the very cycle the first one is being acknowledged, where the address must be replaced rather than held. The bench drives these by raising the event strobe and the clear strobe on the same falling edge so both are seen by one rising edge, then reads status and both address words back through the register window. A busy device byte is also driven to show the clear-on-read path stays inert.

// File: rtl/irqlat_pkg.sv
package irqlat_pkg;

    localparam int unsigned SRC_N    = 2;
    localparam int unsigned SRC_CHAN = 0;
    localparam int unsigned SRC_BERR = 1;

    // Word indices inside the register window
    localparam int unsigned WIX_ADDR_LO = 0;
    localparam int unsigned WIX_ADDR_HI = 1;
    localparam int unsigned WIX_STAT    = 3;
    localparam int unsigned WIX_ENAB    = 5;
    localparam int unsigned WIX_CLR     = 7;

    typedef enum logic [2:0] {
        RSEL_NONE    = 3'd0,
        RSEL_ADDR_LO = 3'd1,
        RSEL_ADDR_HI = 3'd2,
        RSEL_STAT    = 3'd3,
        RSEL_ENAB    = 3'd4,
        RSEL_CLR     = 3'd5
    } rsel_e;

endpackage

// File: rtl/irqlat_dec.sv
module irqlat_dec
    import irqlat_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output rsel_e             rsel
);
    localparam int unsigned WIX_W = ADDR_W - 2;

    logic [WIX_W-1:0] widx;
    logic             aligned;

    always_comb begin
        widx    = addr[ADDR_W-1:2];
        aligned = (addr[1:0] == 2'b00);
        rsel    = RSEL_NONE;
        if (aligned) begin
            if (widx == WIX_W'(WIX_ADDR_LO))      rsel = RSEL_ADDR_LO;
            else if (widx == WIX_W'(WIX_ADDR_HI)) rsel = RSEL_ADDR_HI;
            else if (widx == WIX_W'(WIX_STAT))    rsel = RSEL_STAT;
            else if (widx == WIX_W'(WIX_ENAB))    rsel = RSEL_ENAB;
            else if (widx == WIX_W'(WIX_CLR))     rsel = RSEL_CLR;
            else                                  rsel = RSEL_NONE;
        end
    end

endmodule

// File: rtl/irqlat_stat.sv
module irqlat_stat #(
    parameter int unsigned SRC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] evt,
    input  logic             en_we,
    input  logic [SRC_N-1:0] en_bits,
    input  logic             clr_we,
    input  logic [SRC_N-1:0] clr_bits,
    input  logic             cor_hit,
    output logic [SRC_N-1:0] stat_q,
    output logic [SRC_N-1:0] en_q,
    output logic [SRC_N-1:0] first_evt
);
    typedef struct packed {
        logic [SRC_N-1:0] stat;
        logic [SRC_N-1:0] en;
    } stat_st_t;

    stat_st_t st_d, st_q;
    logic [SRC_N-1:0] clr_vec;
    logic [SRC_N-1:0] evt_ok;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < SRC_N; i++) begin
            clr_vec[i]   = (clr_we && clr_bits[i]) || cor_hit;
            evt_ok[i]    = evt[i] && st_q.en[i];
            // an event counts as first when the bit is idle or being cleared now
            first_evt[i] = evt_ok[i] && (!st_q.stat[i] || clr_vec[i]);
            if (evt_ok[i])        st_d.stat[i] = 1'b1;
            else if (clr_vec[i])  st_d.stat[i] = 1'b0;
            if (en_we && en_bits[i]) st_d.en[i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat_q = st_q.stat;
    assign en_q   = st_q.en;

endmodule

// File: rtl/irqlat_errcap.sv
module irqlat_errcap #(
    parameter int unsigned ERR_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [ERR_W-1:0] addr_in,
    output logic [ERR_W-1:0] addr_q
);
    typedef struct packed {
        logic [ERR_W-1:0] addr;
    } cap_st_t;

    cap_st_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        if (cap) cs_d.addr = addr_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign addr_q = cs_q.addr;

endmodule

// File: rtl/irqlat_rdmux.sv
module irqlat_rdmux
    import irqlat_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ERR_W  = 64,
    parameter int unsigned SRC_N  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd,
    input  rsel_e             rsel,
    input  logic [ERR_W-1:0]  addr,
    input  logic [SRC_N-1:0]  stat,
    input  logic [SRC_N-1:0]  en,
    output logic [DATA_W-1:0] rdata_q
);
    localparam int unsigned PAD_W = 2 * DATA_W;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_st_t;

    rd_st_t rs_d, rs_q;
    logic [PAD_W-1:0] addr_pad;

    always_comb begin
        addr_pad              = '0;
        addr_pad[ERR_W-1:0]   = addr;
        rs_d                  = rs_q;
        if (rd) begin
            rs_d.rdata = '0;
            case (rsel)
                RSEL_ADDR_LO: rs_d.rdata = addr_pad[DATA_W-1:0];
                RSEL_ADDR_HI: rs_d.rdata = addr_pad[PAD_W-1:DATA_W];
                RSEL_STAT:    rs_d.rdata[SRC_N-1:0] = stat;
                RSEL_ENAB:    rs_d.rdata[SRC_N-1:0] = en;
                default:      rs_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign rdata_q = rs_q.rdata;

endmodule

// File: rtl/irqerr_latch.sv
module irqerr_latch
    import irqlat_pkg::*;
#(
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ERR_W     = 64,
    parameter logic [7:0]  IDLE_MASK = 8'h51
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              chan_evt,
    input  logic              berr_evt,
    input  logic [ERR_W-1:0]  berr_addr,
    input  logic              dev_stat_rd,
    input  logic [7:0]        dev_stat_byte,
    output logic              irq_o
);
    rsel_e            rsel;
    logic [SRC_N-1:0] evt;
    logic [SRC_N-1:0] stat_q;
    logic [SRC_N-1:0] en_q;
    logic [SRC_N-1:0] first_evt;
    logic [ERR_W-1:0] err_addr_q;
    logic             cor_hit;
    logic             unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:SRC_N];

    assign evt[SRC_CHAN] = chan_evt;
    assign evt[SRC_BERR] = berr_evt;
    assign cor_hit       = dev_stat_rd && ((dev_stat_byte & IDLE_MASK) != 8'h00);

    irqlat_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (reg_addr),
        .rsel (rsel)
    );

    irqlat_stat #(.SRC_N(SRC_N)) u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (evt),
        .en_we     (reg_wr && (rsel == RSEL_ENAB)),
        .en_bits   (reg_wdata[SRC_N-1:0]),
        .clr_we    (reg_wr && (rsel == RSEL_CLR)),
        .clr_bits  (reg_wdata[SRC_N-1:0]),
        .cor_hit   (cor_hit),
        .stat_q    (stat_q),
        .en_q      (en_q),
        .first_evt (first_evt)
    );

    irqlat_errcap #(.ERR_W(ERR_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (first_evt[SRC_BERR]),
        .addr_in (berr_addr),
        .addr_q  (err_addr_q)
    );

    irqlat_rdmux #(.DATA_W(DATA_W), .ERR_W(ERR_W), .SRC_N(SRC_N)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd      (reg_rd),
        .rsel    (rsel),
        .addr    (err_addr_q),
        .stat    (stat_q),
        .en      (en_q),
        .rdata_q (reg_rdata)
    );

    assign irq_o = |stat_q;

endmodule

// File: rtl/irqlat_chk.sv
module irqlat_chk #(
    parameter int unsigned ADDR_W    = 5,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ERR_W     = 64,
    parameter logic [7:0]  IDLE_MASK = 8'h51
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              chan_evt,
    input logic              berr_evt,
    input logic [ERR_W-1:0]  berr_addr,
    input logic              dev_stat_rd,
    input logic [7:0]        dev_stat_byte,
    input logic              irq_o,
    input logic [1:0]        stat,
    input logic [1:0]        en,
    input logic [ERR_W-1:0]  err_addr
);
    localparam logic [ADDR_W-1:0] CLR_OFS = ADDR_W'(8'h1C);

    logic clr0, clr1, cor;
    assign clr0 = reg_wr && (reg_addr == CLR_OFS) && reg_wdata[0];
    assign clr1 = reg_wr && (reg_addr == CLR_OFS) && reg_wdata[1];
    assign cor  = dev_stat_rd && ((dev_stat_byte & IDLE_MASK) != 8'h00);

    AST_CHAN_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        chan_evt && en[0] |=> stat[0] && irq_o); // R6

    AST_DIS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !en[0] && !stat[0] |=> !stat[0]); // R3

    AST_CLR_BIT0: assert property (@(posedge clk) disable iff (!rst_n)
        clr0 && !chan_evt |=> !stat[0]); // R5

    AST_COR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cor && !chan_evt && !berr_evt |=> (stat == 2'b00) && !irq_o); // R9

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stat[1] && !clr1 && !cor |=> $stable(err_addr)); // R7

    AST_ADDR_CAPT: assert property (@(posedge clk) disable iff (!rst_n)
        berr_evt && en[1] && !stat[1] |=> err_addr == $past(berr_addr)); // R7

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((chan_evt && en[0]) || (berr_evt && en[1]))); // R4

endmodule

bind irqerr_latch irqlat_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ERR_W(ERR_W), .IDLE_MASK(IDLE_MASK)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .chan_evt      (chan_evt),
    .berr_evt      (berr_evt),
    .berr_addr     (berr_addr),
    .dev_stat_rd   (dev_stat_rd),
    .dev_stat_byte (dev_stat_byte),
    .irq_o         (irq_o),
    .stat          (stat_q),
    .en            (en_q),
    .err_addr      (err_addr_q)
);

// File: tb/irqerr_latch_tb.sv
module irqerr_latch_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        chan_evt = 1'b0;
    logic        berr_evt = 1'b0;
    logic [63:0] berr_addr = '0;
    logic        dev_stat_rd = 1'b0;
    logic [7:0]  dev_stat_byte = '0;
    logic        irq_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    irqerr_latch u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chan_evt(chan_evt), .berr_evt(berr_evt), .berr_addr(berr_addr),
        .dev_stat_rd(dev_stat_rd), .dev_stat_byte(dev_stat_byte), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr = 0; reg_rd = 0; chan_evt = 0; berr_evt = 0; dev_stat_rd = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); idle();
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1; reg_addr = a;
        @(negedge clk); idle(); d = reg_rdata;
    endtask

    task automatic pulse(input logic c, input logic b, input logic [63:0] ad);
        @(negedge clk); chan_evt = c; berr_evt = b; berr_addr = ad;
        @(negedge clk); idle();
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(5'h0C, v); check("R1 status", v, 0);
        rd(5'h14, v); check("R1 enable", v, 0);
        rd(5'h00, v); check("R1 addr lo", v, 0);
        rd(5'h04, v); check("R1 addr hi", v, 0);
        check("R1 irq", {31'b0, irq_o}, 0);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        pulse(1, 1, 64'h1111_2222_3333_4444);
        rd(5'h0C, v); check("R3 disabled ignored", v, 0);
        check("R3 disabled irq", {31'b0, irq_o}, 0);
        wr(5'h14, 32'h1);
        rd(5'h14, v); check("R2 enable bit0", v, 1);
        wr(5'h14, 32'h2);
        rd(5'h14, v); check("R2 enable set-only", v, 3);
    endtask

    task automatic t_events();
        logic [31:0] v;
        pulse(1, 0, 0);
        check("R4 irq high", {31'b0, irq_o}, 1);
        rd(5'h0C, v); check("R3 chan sets bit0", v, 1);
        wr(5'h1C, 32'h1);
        check("R4 irq low", {31'b0, irq_o}, 0);
        rd(5'h0C, v); check("R5 clear bit0", v, 0);
        pulse(0, 1, 64'hDEAD_BEEF_0BAD_F00D);
        rd(5'h0C, v); check("R3 berr sets bit1", v, 2);
        rd(5'h00, v); check("R7 addr lo", v, 32'h0BAD_F00D);
        rd(5'h04, v); check("R7 addr hi", v, 32'hDEAD_BEEF);
        pulse(1, 1, 64'h5555_6666_7777_8888);
        rd(5'h00, v); check("R7 hold lo", v, 32'h0BAD_F00D);
        rd(5'h04, v); check("R7 hold hi", v, 32'hDEAD_BEEF);
        wr(5'h1C, 32'h2);
        rd(5'h0C, v); check("R5 selective clear", v, 1);
        wr(5'h1C, 32'h1);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        @(negedge clk); reg_wr = 1; reg_addr = 5'h1C; reg_wdata = 32'h3; chan_evt = 1;
        @(negedge clk); idle();
        rd(5'h0C, v); check("R6 event beats clear", v, 1);
        wr(5'h1C, 32'h1);
        pulse(0, 1, 64'h0000_0001_0000_0002);
        @(negedge clk); reg_wr = 1; reg_addr = 5'h1C; reg_wdata = 32'h2;
        berr_evt = 1; berr_addr = 64'hAAAA_0000_BBBB_0000;
        @(negedge clk); idle();
        rd(5'h0C, v); check("R6 berr beats clear", v, 2);
        rd(5'h00, v); check("R8 recapture lo", v, 32'hBBBB_0000);
        rd(5'h04, v); check("R8 recapture hi", v, 32'hAAAA_0000);
        wr(5'h1C, 32'h2);
        pulse(0, 1, 64'h0123_4567_89AB_CDEF);
        rd(5'h00, v); check("R8 rearm lo", v, 32'h89AB_CDEF);
        wr(5'h1C, 32'h2);
    endtask

    task automatic t_cor();
        logic [31:0] v;
        pulse(1, 1, 64'h0);
        @(negedge clk); dev_stat_rd = 1; dev_stat_byte = 8'h80;
        @(negedge clk); idle();
        rd(5'h0C, v); check("R9 busy no clear", v, 3);
        @(negedge clk); dev_stat_rd = 1; dev_stat_byte = 8'h50;
        @(negedge clk); idle();
        check("R9 irq cleared", {31'b0, irq_o}, 0);
        rd(5'h0C, v); check("R9 idle clears", v, 0);
        @(negedge clk); dev_stat_rd = 1; dev_stat_byte = 8'h01; chan_evt = 1;
        @(negedge clk); idle();
        rd(5'h0C, v); check("R6 event beats read-clear", v, 1);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        rd(5'h08, v); check("R10 unmapped", v, 0);
        rd(5'h0D, v); check("R10 unaligned", v, 0);
        rd(5'h1C, v); check("R10 clear reg reads zero", v, 0);
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_enable();
        t_events();
        t_collide();
        t_cor();
        t_unmapped();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule